// File: doc/BRIEF.md
# Single-Wire Debug Acknowledge Target

This block is the target end of a bidirectional single-wire debug link. When the command decoder reports a command that the core has to execute, the block records one outstanding acknowledge. When the core signals that the command has finished, the block pulls the shared wire low for a fixed number of serial clock ticks. It then drives the wire high for one tick to speed up the rising edge, and then releases the wire. The host never starts this pulse. The target starts it on its own.

An outstanding acknowledge has no time limit. The only way to cancel it is a sync request: the host holds the wire low for at least a sync-length number of serial clock ticks. The block measures how long the wire stays low with a saturating counter that clears whenever the wire is high. When it recognises a sync, it drops the outstanding command. After the host lets the wire go, the block sends back a long low reference pulse, ends it with a speedup tick, and is then ready for a new command. The wire is only ever driven through an output enable, as an open-drain pad would be.

Bit-level shifting and command decoding are not part of this block. They appear only as the `cmd_valid` and `cmd_done` inputs.

Top module: `dbg_ack_target`

## Requirements
- R1: After reset, a `cmd_valid` pulse with `stop_mode` low makes an acknowledge outstanding. A later `cmd_done` pulse starts the acknowledge: `wire_oe` is high in the clock cycle right after the edge at which `cmd_done` was sampled.
- R2: The acknowledge is driven low (`wire_oe`=1, `wire_do`=0) for exactly ACK_LEN serial clock ticks, default 16. It is then driven high (`wire_oe`=1, `wire_do`=1) for one tick. After that, `wire_oe` returns to 0.
- R3: A `cmd_valid` that arrives while an acknowledge is already outstanding is ignored. A single `cmd_done` produces one acknowledge, and a second `cmd_done` produces none.
- R4: A `cmd_valid` sampled while `stop_mode` is high is discarded. No acknowledge follows, even if `cmd_done` comes later.
- R5: `cmd_done` with no acknowledge outstanding has no effect on the wire.
- R6: An outstanding acknowledge never expires. It is still delivered after thousands of idle cycles.
- R7: A wire low level lasting SYNC_LEN serial clock ticks (default 128) is a sync request, and it cancels any outstanding acknowledge. A low level lasting SYNC_LEN-1 ticks is not a sync request and cancels nothing.
- R8: After a sync request, once the wire is high again, the target drives a reference pulse. The pulse is low for REF_LEN ticks (default 128), then high for one tick, then the wire is released. This happens whether or not a command was outstanding.
- R9: Once the reference pulse is over, a new `cmd_valid` followed by `cmd_done` produces a normal acknowledge.
- R10: Every duration (acknowledge length, sync threshold, reference length) is counted in cycles where `sclk_en` is high, not in raw clock cycles.
- R11: While `rst_n` is low, and right after it goes high, `wire_oe` is 0 and no acknowledge is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_en | input | 1 | One-cycle serial clock tick enable |
| wire_in | input | 1 | Synchronised level of the debug wire |
| wire_oe | output | 1 | Output enable of the wire driver |
| wire_do | output | 1 | Level driven while `wire_oe` is high |
| cmd_valid | input | 1 | Pulse: a command that needs core execution was decoded |
| cmd_done | input | 1 | Pulse: the core finished the command |
| stop_mode | input | 1 | Core is entering or in stop mode |

## Verification
On every cycle, the assertions check the shape of any pulse the target drives. A driven-high tick only ever follows a driven-low stretch, the driver releases only after a high tick, and no low stretch runs past the longest configured length. They also check that a pulse starts only after a `cmd_done` or with the wire high. Which commands are accepted, ignored or discarded cannot be seen from one cycle, so only the bench scenarios can show it. The same holds for the absence of a timeout, the exact 127/128-tick sync boundary, and a new command being accepted after a sync.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_PEND,
        LK_ACK,
        LK_SYNC,
        LK_REF
    } link_state_e;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_LOW,
        PG_SPEED
    } pulse_state_e;

endpackage

// File: rtl/dbg_low_timer.sv
module dbg_low_timer #(
    parameter int SYNC_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_in,
    input  logic mask,
    output logic sync_hit
);
    localparam int CW = $clog2(SYNC_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (line_in || mask) begin
            r_d.cnt = '0;
        end else if (tick && (r_q.cnt < CW'(SYNC_LEN))) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_hit = (r_q.cnt == CW'(SYNC_LEN));

endmodule

// File: rtl/dbg_pulse_gen.sv
module dbg_pulse_gen
    import dbg_ack_pkg::*;
#(
    parameter int ACK_LEN = 16,
    parameter int REF_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic sel_ref,
    output logic oe,
    output logic dout,
    output logic busy
);
    localparam int MAXL = (ACK_LEN > REF_LEN) ? ACK_LEN : REF_LEN;
    localparam int CW   = $clog2(MAXL + 1);

    typedef struct packed {
        pulse_state_e  st;
        logic [CW-1:0] cnt;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        unique case (p_q.st)
            PG_IDLE: begin
                if (start) begin
                    p_d.st  = PG_LOW;
                    p_d.cnt = sel_ref ? CW'(REF_LEN - 1) : CW'(ACK_LEN - 1);
                end
            end
            PG_LOW: begin
                if (tick) begin
                    if (p_q.cnt == '0) p_d.st = PG_SPEED;
                    else               p_d.cnt = p_q.cnt - 1'b1;
                end
            end
            PG_SPEED: begin
                if (tick) p_d.st = PG_IDLE;
            end
            default: p_d.st = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.st  <= PG_IDLE;
            p_q.cnt <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign busy = (p_q.st != PG_IDLE);
    assign oe   = busy;
    assign dout = (p_q.st == PG_SPEED);

endmodule

// File: rtl/dbg_ack_target.sv
module dbg_ack_target
    import dbg_ack_pkg::*;
#(
    parameter int ACK_LEN  = 16,
    parameter int SYNC_LEN = 128,
    parameter int REF_LEN  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_en,
    input  logic wire_in,
    output logic wire_oe,
    output logic wire_do,
    input  logic cmd_valid,
    input  logic cmd_done,
    input  logic stop_mode
);
    typedef struct packed {
        link_state_e st;
    } link_t;

    link_t l_d, l_q;
    logic  sync_hit;
    logic  pg_start, pg_ref, pg_busy;

    dbg_low_timer #(.SYNC_LEN(SYNC_LEN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sclk_en),
        .line_in  (wire_in),
        .mask     (pg_busy),
        .sync_hit (sync_hit)
    );

    dbg_pulse_gen #(.ACK_LEN(ACK_LEN), .REF_LEN(REF_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sclk_en),
        .start   (pg_start),
        .sel_ref (pg_ref),
        .oe      (wire_oe),
        .dout    (wire_do),
        .busy    (pg_busy)
    );

    always_comb begin
        l_d      = l_q;
        pg_start = 1'b0;
        pg_ref   = 1'b0;
        unique case (l_q.st)
            LK_IDLE: begin
                if (sync_hit)                    l_d.st = LK_SYNC;
                else if (cmd_valid && !stop_mode) l_d.st = LK_PEND;
            end
            LK_PEND: begin
                if (sync_hit) begin
                    l_d.st = LK_SYNC;
                end else if (cmd_done) begin
                    pg_start = 1'b1;
                    l_d.st   = LK_ACK;
                end
            end
            LK_ACK: begin
                if (!pg_busy) l_d.st = LK_IDLE;
            end
            LK_SYNC: begin
                if (wire_in) begin
                    pg_start = 1'b1;
                    pg_ref   = 1'b1;
                    l_d.st   = LK_REF;
                end
            end
            LK_REF: begin
                if (!pg_busy) l_d.st = LK_IDLE;
            end
            default: l_d.st = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q.st <= LK_IDLE;
        else        l_q    <= l_d;
    end

endmodule

// File: rtl/dbg_ack_target_chk.sv
module dbg_ack_target_chk #(
    parameter int ACK_LEN = 16,
    parameter int REF_LEN = 128
) (
    input logic clk,
    input logic rst_n,
    input logic sclk_en,
    input logic wire_in,
    input logic wire_oe,
    input logic wire_do,
    input logic cmd_done
);
    localparam int MAXL = (ACK_LEN > REF_LEN) ? ACK_LEN : REF_LEN;
    localparam int CW   = $clog2(MAXL + 2);

    logic [CW-1:0] low_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       low_ticks <= '0;
        else if (!(wire_oe && !wire_do))  low_ticks <= '0;
        else if (sclk_en && low_ticks != '1) low_ticks <= low_ticks + 1'b1;
    end

    AST_SPEEDUP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wire_oe && wire_do) |-> $past(wire_oe && !wire_do)); // R2

    AST_RELEASE_AFTER_SPEEDUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wire_oe) |-> $past(wire_do)); // R2

    AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks <= CW'(MAXL)); // R8

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wire_oe) |-> ($past(cmd_done) || $past(wire_in))); // R1

endmodule

bind dbg_ack_target dbg_ack_target_chk #(.ACK_LEN(ACK_LEN), .REF_LEN(REF_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_en  (sclk_en),
    .wire_in  (wire_in),
    .wire_oe  (wire_oe),
    .wire_do  (wire_do),
    .cmd_done (cmd_done)
);

// File: tb/tb_dbg_ack_target.sv
`timescale 1ns/1ps
module tb_dbg_ack_target;
    localparam int ACK_T  = 16;
    localparam int SYNC_T = 128;
    localparam int REF_T  = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wire_in, wire_oe, wire_do;
    logic cmd_valid = 1'b0, cmd_done = 1'b0, stop_mode = 1'b0;
    logic host_low = 1'b0;
    logic sclk_en;
    int   tick_period = 1;
    int   div_q = 0;
    int   n_chk = 0, n_fail = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    always @(posedge clk) div_q <= (div_q + 1 >= tick_period) ? 0 : div_q + 1;
    assign sclk_en = (div_q == 0);
    assign wire_in = !(host_low || (wire_oe && !wire_do));

    dbg_ack_target dut (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .wire_in(wire_in),
        .wire_oe(wire_oe), .wire_do(wire_do), .cmd_valid(cmd_valid),
        .cmd_done(cmd_done), .stop_mode(stop_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_cmd();
        @(negedge clk) cmd_valid = 1'b1;
        @(negedge clk) cmd_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk) cmd_done = 1'b1;
        @(negedge clk) cmd_done = 1'b0;
    endtask

    task automatic host_pull(input int n);
        @(negedge clk) host_low = 1'b1;
        repeat (n) @(negedge clk);
        host_low = 1'b0;
    endtask

    // Waits up to max_wait negedges for the driver, then measures the pulse.
    task automatic grab(input int max_wait, output bit seen, output int lcyc,
                        output int ltick, output int scyc);
        seen = 0; lcyc = 0; ltick = 0; scyc = 0;
        for (int i = 0; i < max_wait && !seen; i++) begin
            if (i > 0 || !wire_oe) @(negedge clk);
            if (wire_oe) seen = 1;
        end
        if (seen) begin
            while (wire_oe) begin
                if (!wire_do) begin
                    lcyc++;
                    if (sclk_en) ltick++;
                end else begin
                    scyc++;
                end
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset();
        bit s; int a, b, c;
        @(negedge clk);
        chk(wire_oe == 1'b0, "R11 oe in reset", wire_oe, 0);
        @(negedge clk) rst_n = 1'b1;
        chk(wire_oe == 1'b0, "R11 oe after reset", wire_oe, 0);
        pulse_done();
        grab(20, s, a, b, c);
        chk(s == 0, "R5 done without pending", s, 0);
    endtask

    task automatic t_basic();
        bit s; int a, b, c;
        pulse_cmd();
        repeat (3) @(negedge clk);
        @(negedge clk) cmd_done = 1'b1;
        @(negedge clk) cmd_done = 1'b0;
        chk(wire_oe == 1'b1, "R1 ack starts next cycle", wire_oe, 1);
        grab(1, s, a, b, c);
        chk(a == ACK_T, "R2 ack low length", a, ACK_T);
        chk(c == 1, "R2 speedup length", c, 1);
        chk(wire_oe == 1'b0, "R2 released", wire_oe, 0);
    endtask

    task automatic t_nested();
        bit s; int a, b, c;
        pulse_cmd();
        pulse_cmd();
        pulse_done();
        grab(3, s, a, b, c);
        chk(s == 1 && a == ACK_T, "R3 first ack", a, ACK_T);
        pulse_done();
        grab(40, s, a, b, c);
        chk(s == 0, "R3 no second ack", s, 0);
    endtask

    task automatic t_stop();
        bit s; int a, b, c;
        @(negedge clk) stop_mode = 1'b1;
        pulse_cmd();
        @(negedge clk) stop_mode = 1'b0;
        pulse_done();
        grab(40, s, a, b, c);
        chk(s == 0, "R4 discarded in stop", s, 0);
        pulse_cmd();
        pulse_done();
        grab(3, s, a, b, c);
        chk(s == 1, "R4 next command acked", s, 1);
    endtask

    task automatic t_no_timeout();
        bit s; int a, b, c;
        pulse_cmd();
        repeat (3000) @(negedge clk);
        pulse_done();
        grab(3, s, a, b, c);
        chk(s == 1 && a == ACK_T, "R6 ack after long wait", s, 1);
    endtask

    task automatic t_short_low();
        bit s; int a, b, c;
        pulse_cmd();
        host_pull(SYNC_T - 1);
        grab(10, s, a, b, c);
        chk(s == 0, "R7 short low no sync", s, 0);
        pulse_done();
        grab(3, s, a, b, c);
        chk(s == 1 && a == ACK_T, "R7 pending survives short low", a, ACK_T);
    endtask

    task automatic t_sync_abort();
        bit s; int a, b, c;
        pulse_cmd();
        host_pull(SYNC_T + 2);
        grab(4, s, a, b, c);
        chk(s == 1 && b == REF_T, "R8 reference low ticks", b, REF_T);
        chk(c == 1, "R8 reference speedup", c, 1);
        pulse_done();
        grab(40, s, a, b, c);
        chk(s == 0, "R7 sync cancels pending", s, 0);
        pulse_cmd();
        pulse_done();
        grab(3, s, a, b, c);
        chk(s == 1 && a == ACK_T, "R9 new command after sync", a, ACK_T);
    endtask

    task automatic t_sync_exact();
        bit s; int a, b, c;
        host_pull(SYNC_T);
        grab(4, s, a, b, c);
        chk(s == 1 && b == REF_T, "R7 exact threshold sync", b, REF_T);
    endtask

    task automatic t_slow_tick();
        bit s; int a, b, c;
        @(negedge clk) tick_period = 4;
        repeat (8) @(negedge clk);
        pulse_cmd();
        pulse_done();
        grab(3, s, a, b, c);
        chk(s == 1 && b == ACK_T, "R10 ack ticks gated", b, ACK_T);
        chk(a > ACK_T, "R10 ack spans more cycles", a, ACK_T * 4);
        host_pull(4 * (SYNC_T + 2));
        grab(10, s, a, b, c);
        chk(s == 1 && b == REF_T, "R10 reference ticks gated", b, REF_T);
        @(negedge clk) tick_period = 1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_nested();
        t_stop();
        t_no_timeout();
        t_short_low();
        t_sync_abort();
        t_sync_exact();
        t_slow_tick();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule